// File: doc/BRIEF.md
# Two-Lane ADC Serial Deserializer

This block takes the serial outputs of an eight-channel converter and rebuilds parallel samples from them. Every channel drives two data lanes, and each lane is sampled on both edges of a DDR bit clock sent by the converter. A separate frame clock, also sent by the converter and also sampled on both edges, rises once every two samples. Its rising edge marks where a frame starts. A frame holds fourteen bit times per lane, which is one sample in its first seven bit times and the next sample in the last seven.

The block runs entirely in the bit-clock domain. It keeps a frame position counter and checks each frame edge against the position it predicts. After enough agreeing frames it declares lock, and from then on it emits one parallel word per sample: all eight channels, 14 bits each, with a single-cycle valid pulse. If a frame edge arrives where it was not expected, the block drops lock, restarts its counter at that edge and searches again. Pad buffers, delay tuning and clock generation are outside the block. The lanes are plain single-ended inputs here.

Top module: `adc_lvds_deser`

## Requirements
- R1: Each lane, and the frame input, is sampled on both bit-clock edges. In stream order, the bit captured at a rising edge comes before the bit captured at the following falling edge.
- R2: A 0-to-1 change between consecutive frame-input samples marks frame position 0 on the bit where the input is first 1. A frame is 14 positions long. Positions 0 to 6 carry the first sample and positions 7 to 13 carry the second.
- R3: Within a sample, the k-th bit on lane A (k = 0 to 6, first sent first) is sample bit 12-2k and the k-th bit on lane B is sample bit 13-2k. Lane A therefore carries the even bits and lane B the odd bits, most significant first.
- R4: The first frame edge after reset only restarts the counter. Lock rises after three further consecutive edges that each fall on the predicted position 0. Two agreeing edges followed by a disagreeing one do not lock.
- R5: While locked, a frame edge at any other position clears lock, restarts the counter at that edge, and needs three new agreeing edges to lock again.
- R6: While locked, each completed sample gives exactly one cycle of `out_valid`. All eight channels appear together, channel c in `out_data[14c+13:14c]`. No pulse is given while unlocked or in the cycle of a disagreeing edge.
- R7: `out_valid` and its data appear on the second rising bit-clock edge after the edge that captured the sample's last bit.
- R8: `out_data` changes only together with an `out_valid` pulse.
- R9: An active-high synchronous reset clears the counters, `lock`, `out_valid` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | DDR bit clock from the converter |
| rst | input | 1 | Synchronous reset, active high |
| frame_in | input | 1 | Frame clock, sampled like a data lane |
| lane_a | input | 8 | Even-bit lane of each channel |
| lane_b | input | 8 | Odd-bit lane of each channel |
| lock | output | 1 | Frame alignment established |
| out_valid | output | 1 | One-cycle strobe per rebuilt sample |
| out_data | output | 112 | Eight 14-bit samples, channel 0 lowest |

## Verification
A sample's last bit passes through the edge capture register, then the pair register, then the output register. Its word is therefore due exactly two rising edges after the edge that captured that bit, and a bit captured on a falling edge lands at the same point. The bench stamps the cycle in which every bit pair is captured and stamps every valid pulse when it is observed at the falling edge. It then requires each word to match the expected sample index and to be stamped exactly two cycles after the pair that held that sample's last bit. Lock acquisition, loss and reacquisition are predicted in whole frames from where the bench places its frame edges, so the exact list of emitted sample indices is known in advance.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

  localparam int DEF_NUM_CH      = 8;
  localparam int DEF_SAMPLE_W    = 14;
  localparam int DEF_LOCK_FRAMES = 3;

  // Where, inside one bit-clock cycle, a frame edge was seen.
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_EARLY = 2'd1,   // on the rising-edge bit
    EDGE_LATE  = 2'd2    // on the falling-edge bit
  } edge_slot_e;

  // Per-cycle command from the aligner to every channel's word builder.
  typedef struct packed {
    logic take;   // a sample completed and may be published
    logic late;   // it completed on the falling-edge bit of the pair
  } slot_ctrl_t;

endpackage

// File: rtl/ddr_pair_capture.sv
// Samples a bus on both clock edges and hands the two bits of each cycle
// over as an aligned pair on the rising edge.
module ddr_pair_capture #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] early_q,
  output logic [W-1:0] late_q
);

  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  always_ff @(posedge clk) begin
    if (rst) rise_q <= '0;
    else     rise_q <= din;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= din;
  end

  // rise_q holds the bit taken half a cycle before fall_q
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= '0;
      late_q  <= '0;
    end else begin
      early_q <= rise_q;
      late_q  <= fall_q;
    end
  end

endmodule

// File: rtl/frame_aligner.sv
// Tracks frame position two bits per cycle, compares frame edges with the
// prediction, and maintains the lock state and the output strobe.
module frame_aligner
  import adc_deser_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int LOCK_FRAMES = DEF_LOCK_FRAMES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frm_early,
  input  logic       frm_late,
  output slot_ctrl_t ctrl,
  output logic       lock_q,
  output logic       valid_q
);

  localparam int BPL        = SAMPLE_W / 2;
  localparam int FRAME_BITS = 2 * BPL;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam int MW         = $clog2(LOCK_FRAMES + 1);
  localparam logic [CW-1:0] POS_LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] POS_MID  = CW'(BPL - 1);
  localparam logic [MW-1:0] MATCH_MAX = MW'(LOCK_FRAMES);

  logic          frm_prev_q;
  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic [MW-1:0] match_q;

  edge_slot_e    slot;
  logic [CW-1:0] pos_e, pos_l, cnt_n;
  logic          predicted, hit, miss, done_e, done_l;

  always_comb begin
    if (!frm_prev_q && frm_early)      slot = EDGE_EARLY;
    else if (!frm_early && frm_late)   slot = EDGE_LATE;
    else                               slot = EDGE_NONE;

    unique case (slot)
      EDGE_EARLY: pos_e = '0;
      EDGE_LATE:  pos_e = POS_LAST;
      default:    pos_e = cnt_q;
    endcase
    pos_l = (pos_e == POS_LAST) ? '0 : pos_e + 1'b1;
    cnt_n = (pos_l == POS_LAST) ? '0 : pos_l + 1'b1;

    predicted = seen_q && ((slot == EDGE_EARLY) ? (cnt_q == '0) : (cnt_q == POS_LAST));
    hit  = (slot != EDGE_NONE) &&  predicted;
    miss = (slot != EDGE_NONE) && !predicted;

    done_e = (pos_e == POS_MID) || (pos_e == POS_LAST);
    done_l = (pos_l == POS_MID) || (pos_l == POS_LAST);

    ctrl.take = (done_e || done_l) && lock_q && !miss;
    ctrl.late = done_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_prev_q <= 1'b0;
      seen_q     <= 1'b0;
      cnt_q      <= '0;
      match_q    <= '0;
      lock_q     <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      frm_prev_q <= frm_late;
      cnt_q      <= cnt_n;
      valid_q    <= ctrl.take;
      if (slot != EDGE_NONE) seen_q <= 1'b1;
      if (miss) begin
        match_q <= '0;
        lock_q  <= 1'b0;
      end else if (hit) begin
        if (match_q != MATCH_MAX) match_q <= match_q + 1'b1;
        if (match_q >= MATCH_MAX - 1'b1) lock_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lane_word_builder.sv
// Keeps a short history of one channel's two lanes and, on command,
// interleaves the last seven bits of each lane into a full sample.
module lane_word_builder
  import adc_deser_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a_early,
  input  logic                a_late,
  input  logic                b_early,
  input  logic                b_late,
  input  slot_ctrl_t          ctrl,
  output logic [SAMPLE_W-1:0] word_q
);

  localparam int BPL = SAMPLE_W / 2;

  logic [BPL-2:0]    hist_a_q, hist_b_q;
  logic [BPL:0]      win_a, win_b;
  logic [BPL-1:0]    sel_a, sel_b;
  logic [SAMPLE_W-1:0] word_n;

  assign win_a = {hist_a_q, a_early, a_late};
  assign win_b = {hist_b_q, b_early, b_late};
  assign sel_a = ctrl.late ? win_a[BPL-1:0] : win_a[BPL:1];
  assign sel_b = ctrl.late ? win_b[BPL-1:0] : win_b[BPL:1];

  // oldest lane bit is sel[BPL-1]; it lands on the two top sample bits
  always_comb begin
    for (int k = 0; k < BPL; k++) begin
      word_n[SAMPLE_W-1-2*k] = sel_b[BPL-1-k];
      word_n[SAMPLE_W-2-2*k] = sel_a[BPL-1-k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_a_q <= '0;
      hist_b_q <= '0;
      word_q   <= '0;
    end else begin
      hist_a_q <= win_a[BPL-2:0];
      hist_b_q <= win_b[BPL-2:0];
      if (ctrl.take) word_q <= word_n;
    end
  end

endmodule

// File: rtl/adc_lvds_deser.sv
module adc_lvds_deser
  import adc_deser_pkg::*;
#(
  parameter int NUM_CH      = DEF_NUM_CH,
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int LOCK_FRAMES = DEF_LOCK_FRAMES
) (
  input  logic                       bit_clk,
  input  logic                       rst,
  input  logic                       frame_in,
  input  logic [NUM_CH-1:0]          lane_a,
  input  logic [NUM_CH-1:0]          lane_b,
  output logic                       lock,
  output logic                       out_valid,
  output logic [NUM_CH*SAMPLE_W-1:0] out_data
);

  localparam int CAP_W = 2 * NUM_CH + 1;

  logic [CAP_W-1:0] cap_e, cap_l;
  slot_ctrl_t       ctrl;

  // bus order: {frame, lane_b, lane_a}
  ddr_pair_capture #(.W(CAP_W)) u_cap (
    .clk     (bit_clk),
    .rst     (rst),
    .din     ({frame_in, lane_b, lane_a}),
    .early_q (cap_e),
    .late_q  (cap_l)
  );

  frame_aligner #(.SAMPLE_W(SAMPLE_W), .LOCK_FRAMES(LOCK_FRAMES)) u_align (
    .clk       (bit_clk),
    .rst       (rst),
    .frm_early (cap_e[CAP_W-1]),
    .frm_late  (cap_l[CAP_W-1]),
    .ctrl      (ctrl),
    .lock_q    (lock),
    .valid_q   (out_valid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lane_word_builder #(.SAMPLE_W(SAMPLE_W)) u_bld (
      .clk     (bit_clk),
      .rst     (rst),
      .a_early (cap_e[c]),
      .a_late  (cap_l[c]),
      .b_early (cap_e[NUM_CH+c]),
      .b_late  (cap_l[NUM_CH+c]),
      .ctrl    (ctrl),
      .word_q  (out_data[c*SAMPLE_W +: SAMPLE_W])
    );
  end

endmodule

// File: rtl/adc_lvds_deser_chk.sv
module adc_lvds_deser_chk #(
  parameter int DATA_W = 112
) (
  input logic              bit_clk,
  input logic              rst,
  input logic              lock,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  a_r6_valid_needs_lock: assert property (@(posedge bit_clk) disable iff (rst)
    out_valid |-> lock);

  a_r6_single_pulse: assert property (@(posedge bit_clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r8_data_holds: assert property (@(posedge bit_clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  a_r9_reset_clears: assert property (@(posedge bit_clk)
    rst |=> (!lock && !out_valid && out_data == '0));

endmodule

bind adc_lvds_deser adc_lvds_deser_chk #(.DATA_W(NUM_CH*SAMPLE_W)) u_chk (
  .bit_clk   (bit_clk),
  .rst       (rst),
  .lock      (lock),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_adc_lvds_deser.sv
module test_adc_lvds_deser;

  localparam int NCH = 8;
  localparam int SW  = 14;
  localparam int DW  = NCH * SW;
  localparam int SLEN_MAX = 1024;

  logic           bit_clk = 1'b0;
  logic           rst = 1'b1;
  logic           frame_in = 1'b0;
  logic [NCH-1:0] lane_a = '0, lane_b = '0;
  logic           lock, out_valid;
  logic [DW-1:0]  out_data;

  adc_lvds_deser i_adc_lvds_deser (
    .bit_clk(bit_clk), .rst(rst), .frame_in(frame_in),
    .lane_a(lane_a), .lane_b(lane_b),
    .lock(lock), .out_valid(out_valid), .out_data(out_data)
  );

  always #5 bit_clk = ~bit_clk;

  int n_vec = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge bit_clk) cyc <= cyc + 1;

  // stream under construction
  logic [NCH-1:0] sa [SLEN_MAX];
  logic [NCH-1:0] sb [SLEN_MAX];
  logic           sf [SLEN_MAX];
  int slen;
  int last_bit [128];
  int pair_cyc [SLEN_MAX/2];
  int mode;

  // observations
  logic [DW-1:0] rec_data [256];
  int  rec_cyc [256];
  int  rec_n = 0;
  int  lock_falls = 0, unlocked_valid = 0, hold_viol = 0;
  logic lock_prev = 1'b0;
  logic [DW-1:0] data_prev = '0;

  always @(negedge bit_clk) begin
    if (!rst) begin
      if (out_valid && rec_n < 256) begin
        rec_data[rec_n] = out_data;
        rec_cyc[rec_n]  = cyc;
        rec_n++;
      end
      if (out_valid && !lock) unlocked_valid++;
      if (!out_valid && out_data != data_prev) hold_viol++;
      if (lock_prev && !lock) lock_falls++;
    end
    lock_prev = lock;
    data_prev = out_data;
  end

  function automatic logic [SW-1:0] sample_val(int md, int s, int c);
    if (md == 0) return SW'((s * 613 + c * 1447 + 91) % 16384);
    case ((s + c) % 3)
      0:       return 14'h3FFF;
      1:       return 14'h2AAA;
      default: return 14'h1555;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_vec(int s);
    logic [DW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*SW +: SW] = sample_val(mode, s, c);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic add_gap(input int n);
    for (int i = 0; i < n; i++) begin
      sa[slen] = '0; sb[slen] = '0; sf[slen] = 1'b0; slen++;
    end
  endtask

  // R2/R3 encoding: positions 0..6 first sample, 7..13 second; lane A bit 12-2k, lane B bit 13-2k
  task automatic add_frame(input int f);
    for (int j = 0; j < 2; j++) begin
      for (int k = 0; k < 7; k++) begin
        for (int c = 0; c < NCH; c++) begin
          logic [SW-1:0] w;
          w = sample_val(mode, 2*f + j, c);
          sa[slen][c] = w[12-2*k];
          sb[slen][c] = w[13-2*k];
        end
        sf[slen] = (j == 0);
        slen++;
      end
      last_bit[2*f + j] = slen - 1;
    end
  endtask

  // R1: the even stream bit goes out for the rising edge, the odd one for the falling edge
  task automatic run_stream();
    int npair;
    npair = (slen + 1) / 2 + 12;
    for (int k = 0; k < npair; k++) begin
      @(negedge bit_clk); #1;
      if (2*k < slen) begin lane_a = sa[2*k]; lane_b = sb[2*k]; frame_in = sf[2*k]; end
      else begin lane_a = '0; lane_b = '0; frame_in = 1'b0; end
      @(posedge bit_clk); #1;
      pair_cyc[k] = cyc;
      if (2*k+1 < slen) begin lane_a = sa[2*k+1]; lane_b = sb[2*k+1]; frame_in = sf[2*k+1]; end
      else begin lane_a = '0; lane_b = '0; frame_in = 1'b0; end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; lane_a = '0; lane_b = '0; frame_in = 1'b0;
    repeat (3) @(posedge bit_clk);
    @(negedge bit_clk);
    chk(!lock && !out_valid && out_data == '0, "R9 reset state", {lock, out_valid, out_data[DW-3:0]}, '0);
    rst = 1'b0;
    slen = 0; rec_n = 0; lock_falls = 0; unlocked_valid = 0; hold_viol = 0;
  endtask

  // compares the first n published words with the listed sample indices (R2/R3/R6) and timing (R7)
  task automatic check_words(input int first_a, input int n_a, input int first_b, input int n_b);
    int i = 0;
    chk(rec_n >= n_a + n_b, "R6 pulse count", DW'(rec_n), DW'(n_a + n_b));
    for (int p = 0; p < n_a + n_b; p++) begin
      int s;
      s = (p < n_a) ? first_a + p : first_b + (p - n_a);
      if (i < rec_n) begin
        chk(rec_data[i] == exp_vec(s), "R2/R3/R6 word", rec_data[i], exp_vec(s));
        chk(rec_cyc[i] == pair_cyc[last_bit[s]/2] + 2, "R7 latency",
            DW'(rec_cyc[i]), DW'(pair_cyc[last_bit[s]/2] + 2));
      end
      i++;
    end
    chk(unlocked_valid == 0, "R6 no pulse while unlocked", DW'(unlocked_valid), '0);
    chk(hold_viol == 0, "R8 data hold", DW'(hold_viol), '0);
  endtask

  // R4: restart edge, then frames 1..3 agree, lock from frame 3
  task automatic t_acquire(input int md);
    mode = md;
    do_reset();
    add_gap(4);
    for (int f = 0; f < 8; f++) add_frame(f);
    run_stream();
    chk(lock == 1'b1, "R4 lock after three frames", DW'(lock), DW'(1));
    check_words(6, 10, 0, 0);
    chk(lock_falls == 0, "R4 lock steady", DW'(lock_falls), '0);
  endtask

  // R5: one extra bit moves the frame edge onto the falling-edge slot
  task automatic t_realign();
    mode = 0;
    do_reset();
    add_gap(4);
    for (int f = 0; f < 6; f++) add_frame(f);
    add_gap(1);
    for (int f = 6; f < 12; f++) add_frame(f);
    run_stream();
    chk(lock_falls == 1, "R5 lock dropped once", DW'(lock_falls), DW'(1));
    chk(lock == 1'b1, "R5 relocked", DW'(lock), DW'(1));
    check_words(6, 6, 18, 6);
  endtask

  // R4: two agreeing frames then a shifted edge must not lock
  task automatic t_short_lock();
    mode = 1;
    do_reset();
    add_gap(4);
    for (int f = 0; f < 3; f++) add_frame(f);
    add_gap(2);
    for (int f = 3; f < 9; f++) add_frame(f);
    run_stream();
    chk(lock_falls == 0, "R4 no early lock", DW'(lock_falls), '0);
    check_words(12, 6, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_acquire(0);
    t_acquire(1);
    t_realign();
    t_short_lock();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule